// File: doc/BRIEF.md
# Dual-Channel Threshold Interrupt Controller

This block turns a stream of measurement results from two channels, ambient light and proximity, into interrupt events for a host. Each new result is compared against a programmable 16-bit window (a high and a low bound) for its channel. A persistence filter per channel demands a run of consecutive out-of-window results before an event counts. Qualified events set sticky flags in an 8-bit flag byte, and an active-low interrupt pin is held low while any flag is set. When the host reads the flags, a single strobe clears them all. While any flag is still pending, new events are dropped.

The proximity channel can instead drive the pin as a near/far indicator with hysteresis. A result above the high bound pulls the pin low. A result below the low bound releases it. In this mode ambient activity never reaches the pin. The mode takes effect only while the proximity event select is non-zero.

Results arrive as valid-only strobes. The block accepts a result in every cycle and has no ready signal, so a producer never sees back-pressure and never needs to hold a result. Configuration, the flag-read strobe and the outputs are plain level or pulse pins.

Top module: `dual_threshold_irq`

## Requirements
- R1: After reset the flag byte is 0x00 and `int_n` is 1.
- R2: With `amb_int_en`=1, an ambient result strictly greater than `amb_thr_hi` qualifies as a high hit, and a result strictly less than `amb_thr_lo` qualifies as a low hit. A qualified high event sets flag bit 4 and a qualified low event sets flag bit 5. A result equal to either bound is inside the window. With `amb_int_en`=0 no ambient result qualifies.
- R3: The ambient persistence code `amb_pers` selects the number of consecutive qualifying results needed: 0→1, 1→2, 2→4, 3→8. An in-window result (or a result that does not qualify) restarts the count.
- R4: `prx_sel` picks the proximity events: 00 none, 01 above `prx_thr_hi` (strictly), 10 below `prx_thr_lo` (strictly), 11 both. A close event sets flag bit 1 and an away event sets flag bit 0.
- R5: The proximity persistence code `prx_pers` selects the number of consecutive qualifying results needed: 0→1, 1→2, 2→3, 3→4, with a restart on any non-qualifying result.
- R6: When an event fires, that channel's count returns to zero, so the next event needs a full new run.
- R7: Outside detection-logic mode, `int_n` is 0 exactly while the flag byte is non-zero.
- R8: A `flag_rd` pulse clears every flag in the next cycle, which releases `int_n` in normal mode.
- R9: While the flag byte is non-zero, new events are not recorded. If `flag_rd` coincides with an event, the event is recorded only when the flag byte was zero in that cycle.
- R10: With `logic_mode`=1 and `prx_sel`≠00, `int_n` goes to 0 after a proximity result above `prx_thr_hi` and to 1 after one below `prx_thr_lo`. Otherwise it holds, and ambient results and flags do not move it. With `prx_sel`=00 the mode is inactive and R7 applies.
- R11: A `prot_evt` pulse is an event that sets flag bit 6, subject to R9.
- R12: Flag bits 7, 3 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| amb_vld | input | 1 | Ambient result valid strobe |
| amb_val | input | 16 | Ambient result |
| prx_vld | input | 1 | Proximity result valid strobe |
| prx_val | input | 16 | Proximity result |
| amb_int_en | input | 1 | Ambient event enable |
| amb_pers | input | 2 | Ambient persistence code |
| amb_thr_hi | input | 16 | Ambient high bound |
| amb_thr_lo | input | 16 | Ambient low bound |
| prx_pers | input | 2 | Proximity persistence code |
| prx_sel | input | 2 | Proximity event select |
| prx_thr_hi | input | 16 | Proximity high bound |
| prx_thr_lo | input | 16 | Proximity low bound |
| logic_mode | input | 1 | Near/far pin mode request |
| prot_evt | input | 1 | Protection event pulse |
| flag_rd | input | 1 | Host read of the flag byte (clears it) |
| flags | output | 8 | Sticky flag byte |
| int_n | output | 1 | Active-low interrupt pin |

## Verification
The critical collision is a host read of the flag byte landing in the same cycle as a newly qualified event from either channel or from the protection input. The bench provokes it both with flags pending and with flags empty, and random stimulus raises read strobes often enough that the coincidence recurs with both channels firing together. A reference model predicts the flag byte and pin each cycle. It drops the event when flags were pending and keeps it when they were empty.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

  localparam int FLAG_W       = 8;
  localparam int FB_PROT      = 6;
  localparam int FB_AMB_LO    = 5;
  localparam int FB_AMB_HI    = 4;
  localparam int FB_PRX_CLOSE = 1;
  localparam int FB_PRX_AWAY  = 0;

  localparam logic [FLAG_W-1:0] FLAG_USED =
    (FLAG_W'(1) << FB_PROT)   | (FLAG_W'(1) << FB_AMB_LO) |
    (FLAG_W'(1) << FB_AMB_HI) | (FLAG_W'(1) << FB_PRX_CLOSE) |
    (FLAG_W'(1) << FB_PRX_AWAY);

  // How a 2-bit persistence code turns into a hit count.
  typedef enum logic [0:0] {PERS_POW2, PERS_LINEAR} pers_map_e;

  function automatic logic [3:0] pers_need(pers_map_e m, logic [1:0] code);
    if (m == PERS_POW2) return 4'd1 << code;
    else                return {2'b00, code} + 4'd1;
  endfunction

endpackage

// File: rtl/thr_window_cmp.sv
module thr_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] val,
  input  logic [DATA_W-1:0] thr_hi,
  input  logic [DATA_W-1:0] thr_lo,
  output logic              above,
  output logic              below
);
  always_comb begin
    above = (val > thr_hi);
    below = (val < thr_lo);
  end
endmodule

// File: rtl/thr_persist.sv
module thr_persist
  import thr_irq_pkg::*;
#(
  parameter int        CNT_W = 4,
  parameter pers_map_e MAP   = PERS_POW2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic       hit,
  input  logic [1:0] code,
  output logic       fire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] need;

  always_comb begin
    need    = CNT_W'(pers_need(MAP, code));
    cnt_inc = cnt_q + 1'b1;
    fire    = smp_vld && hit && (cnt_inc >= need);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (smp_vld) begin
      if (hit && !fire)         cnt_q <= cnt_inc;
      else                      cnt_q <= '0;
    end
  end

  // R6: a fired event leaves the run count empty.
  a_r6_fire_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));

  // R3: a non-qualifying result breaks the run.
  a_r3_gap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !hit) |=> (cnt_q == '0));

endmodule

// File: rtl/thr_flag_bank.sv
module thr_flag_bank
  import thr_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] evt,
  input  logic              rd,
  output logic [FLAG_W-1:0] flags
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] kept;
  logic              pending;

  always_comb begin
    pending = |flags_q;
    kept    = rd ? '0 : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (pending) flags_q <= kept;
    else              flags_q <= kept | (evt & FLAG_USED);
  end

  assign flags = flags_q;

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0 && rd) |=> (flags_q == '0));

  a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q != '0 && !rd) |=> (flags_q == $past(flags_q)));

  a_r12_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~FLAG_USED) == '0));

endmodule

// File: rtl/dual_threshold_irq.sv
module dual_threshold_irq
  import thr_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              amb_vld,
  input  logic [DATA_W-1:0] amb_val,
  input  logic              prx_vld,
  input  logic [DATA_W-1:0] prx_val,
  input  logic              amb_int_en,
  input  logic [1:0]        amb_pers,
  input  logic [DATA_W-1:0] amb_thr_hi,
  input  logic [DATA_W-1:0] amb_thr_lo,
  input  logic [1:0]        prx_pers,
  input  logic [1:0]        prx_sel,
  input  logic [DATA_W-1:0] prx_thr_hi,
  input  logic [DATA_W-1:0] prx_thr_lo,
  input  logic              logic_mode,
  input  logic              prot_evt,
  input  logic              flag_rd,
  output logic [7:0]        flags,
  output logic              int_n
);
  localparam int NCH = 2;
  localparam int CH_AMB = 0;
  localparam int CH_PRX = 1;

  logic [DATA_W-1:0] ch_val [NCH];
  logic [DATA_W-1:0] ch_hi  [NCH];
  logic [DATA_W-1:0] ch_lo  [NCH];
  logic [1:0]        ch_code[NCH];
  logic [NCH-1:0]    ch_vld, ch_above, ch_below, ch_hit, ch_fire;
  logic [FLAG_W-1:0] evt;
  logic [FLAG_W-1:0] flag_q;
  logic              logic_act;
  logic              near_q;

  always_comb begin
    ch_val[CH_AMB]  = amb_val;    ch_val[CH_PRX]  = prx_val;
    ch_hi[CH_AMB]   = amb_thr_hi; ch_hi[CH_PRX]   = prx_thr_hi;
    ch_lo[CH_AMB]   = amb_thr_lo; ch_lo[CH_PRX]   = prx_thr_lo;
    ch_code[CH_AMB] = amb_pers;   ch_code[CH_PRX] = prx_pers;
    ch_vld          = {prx_vld, amb_vld};
    ch_hit[CH_AMB]  = amb_int_en && (ch_above[CH_AMB] || ch_below[CH_AMB]);
    ch_hit[CH_PRX]  = (prx_sel[0] && ch_above[CH_PRX]) ||
                      (prx_sel[1] && ch_below[CH_PRX]);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam pers_map_e MAP = (g == CH_AMB) ? PERS_POW2 : PERS_LINEAR;

    thr_window_cmp #(.DATA_W(DATA_W)) u_cmp (
      .val(ch_val[g]), .thr_hi(ch_hi[g]), .thr_lo(ch_lo[g]),
      .above(ch_above[g]), .below(ch_below[g])
    );

    thr_persist #(.CNT_W(CNT_W), .MAP(MAP)) u_pers (
      .clk(clk), .rst_n(rst_n), .smp_vld(ch_vld[g]), .hit(ch_hit[g]),
      .code(ch_code[g]), .fire(ch_fire[g])
    );
  end

  always_comb begin
    evt               = '0;
    evt[FB_PROT]      = prot_evt;
    evt[FB_AMB_HI]    = ch_fire[CH_AMB] && ch_above[CH_AMB];
    evt[FB_AMB_LO]    = ch_fire[CH_AMB] && ch_below[CH_AMB];
    evt[FB_PRX_CLOSE] = ch_fire[CH_PRX] && prx_sel[0] && ch_above[CH_PRX];
    evt[FB_PRX_AWAY]  = ch_fire[CH_PRX] && prx_sel[1] && ch_below[CH_PRX];
  end

  thr_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .rd(flag_rd), .flags(flag_q)
  );

  assign logic_act = logic_mode && (prx_sel != 2'b00);

  // Near/far state with hysteresis, driven by raw proximity compares.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               near_q <= 1'b0;
    else if (!logic_act)                      near_q <= 1'b0;
    else if (prx_vld && ch_above[CH_PRX])     near_q <= 1'b1;
    else if (prx_vld && ch_below[CH_PRX])     near_q <= 1'b0;
  end

  assign flags = flag_q;
  assign int_n = logic_act ? !near_q : (flag_q == '0);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R10: in pin mode only a proximity result may move the pin.
  a_r10_pin_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && logic_act && $past(logic_act) && !$past(prx_vld))
      |-> (int_n == $past(int_n)));

  // R7: pending flags hold the pin low outside pin mode.
  a_r7_pending_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!logic_act && $rose(|flag_q)) |-> !int_n);

endmodule

// File: tb/dual_threshold_irq_tb.sv
`timescale 1ns/1ps
module dual_threshold_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic amb_vld = 0, prx_vld = 0, amb_int_en = 0, logic_mode = 0, prot_evt = 0, flag_rd = 0;
  logic [15:0] amb_val = 0, prx_val = 0, amb_thr_hi = 0, amb_thr_lo = 0, prx_thr_hi = 0, prx_thr_lo = 0;
  logic [1:0] amb_pers = 0, prx_pers = 0, prx_sel = 0;
  logic [7:0] flags;
  logic int_n;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_flags = 0;
  int m_amb_cnt = 0, m_prx_cnt = 0;
  bit m_near = 0;

  always #4 clk = ~clk;

  dual_threshold_irq u_dut (
    .clk(clk), .rst_n(rst_n), .amb_vld(amb_vld), .amb_val(amb_val),
    .prx_vld(prx_vld), .prx_val(prx_val), .amb_int_en(amb_int_en),
    .amb_pers(amb_pers), .amb_thr_hi(amb_thr_hi), .amb_thr_lo(amb_thr_lo),
    .prx_pers(prx_pers), .prx_sel(prx_sel), .prx_thr_hi(prx_thr_hi),
    .prx_thr_lo(prx_thr_lo), .logic_mode(logic_mode), .prot_evt(prot_evt),
    .flag_rd(flag_rd), .flags(flags), .int_n(int_n)
  );

  function automatic int amb_need(logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 8; endcase
  endfunction

  function automatic int prx_need(logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 3; default: return 4; endcase
  endfunction

  task automatic model_step();
    logic [7:0] ev = 8'h00;
    logic [7:0] nf;
    bit a_hi, a_lo, p_hi, p_lo, p_hit, act;
    if (amb_vld) begin
      a_hi = amb_val > amb_thr_hi; a_lo = amb_val < amb_thr_lo;
      if (amb_int_en && (a_hi || a_lo)) begin
        if (m_amb_cnt + 1 >= amb_need(amb_pers)) begin
          ev[4] = a_hi; ev[5] = a_lo; m_amb_cnt = 0;
        end else m_amb_cnt++;
      end else m_amb_cnt = 0;
    end
    p_hi = prx_val > prx_thr_hi; p_lo = prx_val < prx_thr_lo;
    if (prx_vld) begin
      p_hit = (prx_sel[0] && p_hi) || (prx_sel[1] && p_lo);
      if (p_hit) begin
        if (m_prx_cnt + 1 >= prx_need(prx_pers)) begin
          ev[1] = prx_sel[0] && p_hi; ev[0] = prx_sel[1] && p_lo; m_prx_cnt = 0;
        end else m_prx_cnt++;
      end else m_prx_cnt = 0;
    end
    ev[6] = prot_evt;
    nf = flag_rd ? 8'h00 : m_flags;
    if (m_flags == 8'h00) nf = nf | ev;
    m_flags = nf;
    act = logic_mode && (prx_sel != 2'b00);
    if (!act) m_near = 0;
    else if (prx_vld && p_hi) m_near = 1;
    else if (prx_vld && p_lo) m_near = 0;
  endtask

  task automatic compare(string tag);
    bit exp_int;
    exp_int = (logic_mode && prx_sel != 2'b00) ? !m_near : (m_flags == 8'h00);
    checks++;
    if (flags !== m_flags) begin
      errors++;
      $display("FAIL %s flags actual=%02h expected=%02h", tag, flags, m_flags);
    end
    checks++;
    if (int_n !== exp_int) begin
      errors++;
      $display("FAIL %s int_n actual=%0b expected=%0b", tag, int_n, exp_int);
    end
  endtask

  // Inputs are set right after a negedge; one clock edge later, outputs are compared.
  task automatic step(string tag);
    model_step();
    @(posedge clk); @(negedge clk);
    compare(tag);
    amb_vld = 0; prx_vld = 0; prot_evt = 0; flag_rd = 0;
  endtask

  task automatic amb(logic [15:0] v, string tag);
    amb_vld = 1; amb_val = v; step(tag);
  endtask

  task automatic prx(logic [15:0] v, string tag);
    prx_vld = 1; prx_val = v; step(tag);
  endtask

  task automatic rd(string tag);
    flag_rd = 1; step(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset");

    // R2 strict ambient bounds
    amb_int_en = 1; amb_pers = 0; amb_thr_hi = 16'd1000; amb_thr_lo = 16'd100;
    amb(16'd1000, "R2 equal high is inside");
    amb(16'd1001, "R2 above high sets bit4");
    rd("R8 read clears");
    amb(16'd100, "R2 equal low is inside");
    amb(16'd99, "R2 below low sets bit5");
    rd("R8 read clears");
    amb_int_en = 0;
    amb(16'd5000, "R2 disabled ambient");
    amb_int_en = 1;

    // R3 ambient persistence 4
    amb_pers = 2;
    amb(16'd2000, "R3 hit1"); amb(16'd2000, "R3 hit2"); amb(16'd2000, "R3 hit3");
    amb(16'd500, "R3 in-window restart");
    amb(16'd2000, "R3 hit1"); amb(16'd2000, "R3 hit2"); amb(16'd2000, "R3 hit3");
    amb(16'd2000, "R3 hit4 fires");
    rd("R8 read clears");
    amb_pers = 3;
    for (int i = 0; i < 8; i++) amb(16'd3, "R3 eight low hits");
    rd("R8 read clears");

    // R5 / R6 proximity persistence and restart
    prx_sel = 2'b11; prx_pers = 3; prx_thr_hi = 16'd800; prx_thr_lo = 16'd200;
    for (int i = 0; i < 4; i++) prx(16'd900, "R5 four close hits");
    rd("R8 read clears");
    for (int i = 0; i < 3; i++) prx(16'd900, "R6 fresh run needed");
    prx(16'd900, "R6 fresh run fires");
    rd("R8 read clears");
    prx_pers = 1;
    prx(16'd100, "R5 away hit1"); prx(16'd100, "R5 away hit2 fires");
    rd("R8 read clears");

    // R4 event select
    prx_pers = 0;
    prx_sel = 2'b01; prx(16'd50, "R4 select close ignores away");
    prx(16'd801, "R4 close sets bit1"); rd("R8 read clears");
    prx_sel = 2'b10; prx(16'd9000, "R4 select away ignores close");
    prx(16'd199, "R4 away sets bit0"); rd("R8 read clears");
    prx_sel = 2'b00; prx(16'd9000, "R4 select none");

    // R9 lockout and read collision, R11 protection
    prot_evt = 1; step("R11 protection sets bit6");
    amb_pers = 0; amb(16'd9000, "R9 locked out while pending");
    flag_rd = 1; amb_vld = 1; amb_val = 16'd9000; step("R9 read with pending drops event");
    flag_rd = 1; amb_vld = 1; amb_val = 16'd9000; step("R9 read with empty keeps event");
    rd("R8 read clears");
    compare("R12 unused bits zero");

    // R10 pin mode
    logic_mode = 1; prx_sel = 2'b01;
    prx(16'd900, "R10 near pulls pin low");
    amb(16'd9000, "R10 ambient does not move pin");
    prx(16'd500, "R10 inside hysteresis holds");
    prx(16'd100, "R10 far releases pin");
    prx_sel = 2'b00; step("R10 inactive without select gives R7");
    rd("R8 read clears");
    logic_mode = 0;

    // Random mix
    amb_thr_hi = 16'hC000; amb_thr_lo = 16'h4000;
    prx_thr_hi = 16'hA000; prx_thr_lo = 16'h3000;
    for (int n = 0; n < 6000; n++) begin
      if (n % 300 == 0) begin
        r = $urandom;
        amb_pers = r[1:0]; prx_pers = r[3:2]; prx_sel = r[5:4];
        amb_int_en = r[6] | r[7]; logic_mode = (r[10:8] == 3'd0);
      end
      r = $urandom;
      amb_vld = r[0]; prx_vld = r[1];
      amb_val = {r[3:2], r[15:2]};
      prx_val = {r[5:4], r[19:6]};
      if (r[22:20] == 3'd0) amb_val = (r[23]) ? amb_thr_hi : amb_thr_lo;
      flag_rd = (r[26:24] == 3'd0);
      prot_evt = (r[31:27] == 5'd0);
      step("R9 random collision model");
    end
    finish_run();
  end
endmodule